// File: doc/BRIEF.md
# Decaying Active Circuit Counter

This block estimates how many virtual circuits are active on a link, counting each one over a run of averaging intervals. A plain tally of the circuits that sent a cell in the last interval undercounts slow circuits, which may send nothing in a given interval. To avoid this, the block keeps a fractional activity level for every circuit. A cell from a circuit raises its level to one. A circuit that stays silent for a whole interval has its level scaled down by a fixed decay factor. The estimate is the sum of all levels, reported in fixed point. It feeds a fair-share divider downstream, so it never reports less than one.

Cells arrive as a valid pulse with a circuit index. An interval-end strobe starts a walk over the level table, one entry per clock. Each step either keeps a level that was refreshed during the interval or decays it, and adds the result to a running sum. The previous estimate stays on the output until the walk finishes. A one-cycle done pulse then marks the new value.

Two states govern the block. ST_IDLE takes cells and waits for the strobe; the transition T_START (strobe seen) enters ST_WALK with the pointer at entry 0. ST_WALK visits one entry per clock; T_ADVANCE steps the pointer, and T_FINISH (last entry visited) publishes the sum and returns to ST_IDLE.

Top module: `actv_decay_counter`

## Requirements
- R1: After reset every activity level is zero, `count_o` reads 1.0 (4096 with the default 12 fraction bits) and `done_o` is low.
- R2: Levels are unsigned fixed point with FRAC_W fraction bits, so 1.0 is 2^FRAC_W. A cell for circuit i sets level i to exactly 1.0, and that circuit contributes 1.0 to the sum of the interval it falls in.
- R3: A circuit that saw no cell during the interval has its level replaced by floor(level × DECAY / 2^FRAC_W) when the walk visits it (default DECAY 3840, that is 0.9375).
- R4: `count_o` is the sum of all levels after the update, in the same fixed point. It changes, together with a one-cycle pulse on `done_o`, at the N-th rising edge after the edge that samples `intv_end_i`.
- R5: While the walk runs, `count_o` holds the value from the previous interval.
- R6: During a walk, a cell for an entry the pointer has not yet passed (index greater than or equal to the current pointer) sets that entry to 1.0 and exempts it from decay in this walk. A cell for the entry being visited in the same cycle counts toward the current interval only.
- R7: During a walk, a cell for an entry already visited (index below the pointer) sets it to 1.0 and counts as activity in the next interval. It does not change the sum being built.
- R8: Decay truncates, so a level below one LSB becomes exactly zero, and repeated silent intervals drive a level to zero.
- R9: `count_o` is never below 1.0; a smaller sum is reported as 1.0.
- R10: An `intv_end_i` pulse that arrives while a walk is running is ignored; it neither restarts nor extends the walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cell_v_i | input | 1 | A cell from circuit `cell_idx_i` was seen this cycle |
| cell_idx_i | input | IDX_W | Circuit index of the cell |
| intv_end_i | input | 1 | End of averaging interval, starts the walk |
| count_o | output | CNT_W | Estimated active count, FRAC_W fraction bits, at least 1.0 |
| done_o | output | 1 | One-cycle pulse when `count_o` takes a new value |

## Verification
A cell write and the walk's own update can hit the same table entry in one cycle. This happens when a cell carries the index the pointer is visiting. The bench times cells into chosen walk cycles so that one lands on an unvisited entry, one on a visited entry and one exactly on the pointer. It judges the outcome from two sums: the sum published at the end of that walk, and the sum of the silent interval after it. The second sum shows whether the collision leaked activity into the next interval. Another walk receives a second interval-end strobe midway, and the bench checks that exactly one done pulse results.

// File: rtl/acd_pkg.sv
package acd_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WALK = 1'b1
    } acd_state_e;
endpackage

// File: rtl/acd_decay.sv
module acd_decay #(
    parameter int FRAC_W = 12,
    parameter int DECAY  = 3840,
    localparam int LVL_W = FRAC_W + 1
) (
    input  logic [LVL_W-1:0] lvl_i,
    output logic [LVL_W-1:0] lvl_o
);
    localparam int PROD_W = LVL_W + FRAC_W;
    localparam logic [FRAC_W-1:0] FACTOR = FRAC_W'(DECAY);

    logic [PROD_W-1:0] prod;

    always_comb begin
        prod  = PROD_W'(lvl_i) * PROD_W'(FACTOR);
        lvl_o = LVL_W'(prod >> FRAC_W);
    end
endmodule

// File: rtl/acd_store.sv
module acd_store #(
    parameter int N      = 16,
    parameter int FRAC_W = 12,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1,
    localparam int LVL_W = FRAC_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cell_v,
    input  logic [IDX_W-1:0] cell_idx,
    input  logic             walk_v,
    input  logic [IDX_W-1:0] walk_idx,
    input  logic [LVL_W-1:0] walk_lvl,
    output logic [LVL_W-1:0] rd_lvl,
    output logic             rd_seen
);
    localparam logic [LVL_W-1:0] ONE = {1'b1, {FRAC_W{1'b0}}};

    logic [LVL_W-1:0] lvl_q [N];
    logic [N-1:0]     seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q  <= '{default: '0};
            seen_q <= '0;
        end else begin
            if (walk_v) begin
                lvl_q[walk_idx]  <= walk_lvl;
                seen_q[walk_idx] <= 1'b0;
            end
            if (cell_v) begin
                lvl_q[cell_idx] <= ONE;
                if (!(walk_v && cell_idx == walk_idx)) begin
                    seen_q[cell_idx] <= 1'b1;
                end
            end
        end
    end

    assign rd_lvl  = lvl_q[walk_idx];
    assign rd_seen = seen_q[walk_idx];
endmodule

// File: rtl/actv_decay_counter.sv
module actv_decay_counter #(
    parameter int N      = 16,
    parameter int FRAC_W = 12,
    parameter int DECAY  = 3840,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1,
    localparam int LVL_W = FRAC_W + 1,
    localparam int CNT_W = IDX_W + FRAC_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cell_v_i,
    input  logic [IDX_W-1:0] cell_idx_i,
    input  logic             intv_end_i,
    output logic [CNT_W-1:0] count_o,
    output logic             done_o
);
    import acd_pkg::*;

    localparam logic [LVL_W-1:0] ONE     = {1'b1, {FRAC_W{1'b0}}};
    localparam logic [CNT_W-1:0] ONE_CNT = CNT_W'(ONE);
    localparam logic [IDX_W-1:0] LAST    = IDX_W'(N - 1);

    acd_state_e       state_q, state_d;
    logic [IDX_W-1:0] ptr_q, ptr_d;
    logic [CNT_W-1:0] acc_q, acc_d;
    logic [CNT_W-1:0] count_q, count_d;
    logic             done_q, done_d;

    logic             walk_v, walk_last, hit;
    logic [LVL_W-1:0] rd_lvl, dec_lvl, walk_lvl;
    logic             rd_seen;
    logic [CNT_W-1:0] sum_nxt;

    acd_store #(.N(N), .FRAC_W(FRAC_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .cell_v   (cell_v_i),
        .cell_idx (cell_idx_i),
        .walk_v   (walk_v),
        .walk_idx (ptr_q),
        .walk_lvl (walk_lvl),
        .rd_lvl   (rd_lvl),
        .rd_seen  (rd_seen)
    );

    acd_decay #(.FRAC_W(FRAC_W), .DECAY(DECAY)) u_decay (
        .lvl_i (rd_lvl),
        .lvl_o (dec_lvl)
    );

    // Per-entry update seen by the walk
    always_comb begin
        walk_v    = (state_q == ST_WALK);
        walk_last = walk_v && (ptr_q == LAST);
        hit       = rd_seen || (cell_v_i && cell_idx_i == ptr_q);
        walk_lvl  = hit ? ONE : dec_lvl;
        sum_nxt   = acc_q + CNT_W'(walk_lvl);
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ptr_q   <= '0;
            acc_q   <= '0;
            count_q <= ONE_CNT;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
            acc_q   <= acc_d;
            count_q <= count_d;
            done_q  <= done_d;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d = state_q;
        ptr_d   = ptr_q;
        acc_d   = acc_q;
        count_d = count_q;
        done_d  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (intv_end_i) begin
                    state_d = ST_WALK;
                    ptr_d   = '0;
                    acc_d   = '0;
                end
            end
            ST_WALK: begin
                if (ptr_q == LAST) begin
                    state_d = ST_IDLE;
                    count_d = (sum_nxt < ONE_CNT) ? ONE_CNT : sum_nxt;
                    done_d  = 1'b1;
                end else begin
                    ptr_d = ptr_q + 1'b1;
                    acc_d = sum_nxt;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign count_o = count_q;
    assign done_o  = done_q;
endmodule

// File: rtl/acd_checker.sv
module acd_checker #(
    parameter int FRAC_W = 12,
    parameter int CNT_W  = 17,
    localparam int LVL_W = FRAC_W + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             walk_v,
    input logic             walk_last,
    input logic             rd_seen,
    input logic [LVL_W-1:0] rd_lvl,
    input logic [LVL_W-1:0] dec_lvl,
    input logic [CNT_W-1:0] count_o,
    input logic             done_o
);
    localparam logic [CNT_W-1:0] ONE_CNT = CNT_W'(1) << FRAC_W;
    localparam logic [LVL_W-1:0] ONE     = {1'b1, {FRAC_W{1'b0}}};

    p_count_floor_r9: assert property (@(posedge clk) disable iff (!rst_n)
        count_o >= ONE_CNT);

    p_hold_walk_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_v && !walk_last) |=> $stable(count_o));

    p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_after_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
        walk_last |=> done_o);

    p_seen_is_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_v && rd_seen) |-> rd_lvl == ONE);

    p_decay_shrinks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_v && rd_lvl != '0) |-> dec_lvl < rd_lvl);

    p_walk_continues_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_v && !walk_last) |=> walk_v);
endmodule

bind actv_decay_counter acd_checker #(.FRAC_W(FRAC_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .walk_v    (walk_v),
    .walk_last (walk_last),
    .rd_seen   (rd_seen),
    .rd_lvl    (rd_lvl),
    .dec_lvl   (dec_lvl),
    .count_o   (count_o),
    .done_o    (done_o)
);

// File: tb/actv_decay_counter_bench.sv
module actv_decay_counter_bench;
    localparam int N     = 4;
    localparam int IDX_W = 2;
    localparam int CNT_W = IDX_W + 12 + 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cell_v_i = 1'b0;
    logic [IDX_W-1:0] cell_idx_i = '0;
    logic             intv_end_i = 1'b0;
    logic [CNT_W-1:0] count_o;
    logic             done_o;

    int n_total = 0;
    int n_fail  = 0;
    int n_pulse = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    actv_decay_counter #(.N(N), .FRAC_W(12), .DECAY(3840)) u_actv_decay_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .cell_v_i   (cell_v_i),
        .cell_idx_i (cell_idx_i),
        .intv_end_i (intv_end_i),
        .count_o    (count_o),
        .done_o     (done_o)
    );

    always @(posedge clk) if (done_o) n_pulse++;

    // Circuits active in each interval and the sum expected afterwards
    localparam logic [3:0] MASKS [5] = '{4'b1111, 4'b0011, 4'b0001, 4'b0000, 4'b1110};
    localparam int         EXPS  [5] = '{16384, 15872, 15136, 14190, 15888};

    task automatic check(input string req, input int act, input int exp);
        n_total++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report;
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    endtask

    // Strobe, then one cell injection slot per walk cycle (-1 = none)
    task automatic run_walk(input int i0, input int i1, input int i2, input int i3,
                            input bit extra_strobe, input int held);
        @(negedge clk) intv_end_i = 1'b1;
        @(negedge clk) intv_end_i = 1'b0;
        for (int p = 0; p < N; p++) begin
            int sel;
            if (p > 0) @(negedge clk);
            case (p)
                0: sel = i0;
                1: sel = i1;
                2: sel = i2;
                default: sel = i3;
            endcase
            cell_v_i   = (sel >= 0);
            cell_idx_i = IDX_W'(sel < 0 ? 0 : sel);
            intv_end_i = extra_strobe && (p == 2);
            if (held >= 0 && p == 1) check("R5 count held during walk", int'(count_o), held);
        end
        @(negedge clk);
        cell_v_i   = 1'b0;
        intv_end_i = 1'b0;
        check("R4 done pulse timing", int'(done_o), 1);
        @(negedge clk);
        check("R4 done single cycle", int'(done_o), 0);
    endtask

    task automatic end_interval(input logic [3:0] mask);
        for (int i = 0; i < N; i++) begin
            if (mask[i]) begin
                @(negedge clk);
                cell_v_i   = 1'b1;
                cell_idx_i = IDX_W'(i);
            end
        end
        @(negedge clk) cell_v_i = 1'b0;
        run_walk(-1, -1, -1, -1, 1'b0, -1);
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_total++;
        n_fail++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        int base;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset count", int'(count_o), 4096);
        check("R1 reset done", int'(done_o), 0);
        rst_n = 1'b1;

        // R9: no activity at all, the sum of zero is clamped to 1.0
        end_interval(4'b0000);
        check("R9 clamp to one", int'(count_o), 4096);

        // Vector table: R2, R3, R4
        for (int v = 0; v < 5; v++) begin
            end_interval(MASKS[v]);
            check("R2 R3 R4 interval sum", int'(count_o), EXPS[v]);
        end

        end_interval(4'b1111);
        check("R2 all active", int'(count_o), 16384);

        // Walk A: cell for entry 3 at pointer 1 (R6), entry 0 at pointer 2 (R7)
        run_walk(-1, 3, 0, -1, 1'b0, 16384);
        check("R6 R7 walk sum", int'(count_o), 15616);

        // Walk B: entry 0 carried over (R7); cell for entry 1 at pointer 1 (R6 collision)
        run_walk(-1, 1, -1, -1, 1'b0, 15616);
        check("R6 R7 carry and collision", int'(count_o), 15632);

        // Walk C: collision must not leak; extra strobe mid walk (R10)
        base = n_pulse;
        run_walk(-1, -1, -1, -1, 1'b1, 15632);
        repeat (10) @(negedge clk);
        check("R6 collision not carried", int'(count_o), 14655);
        check("R10 single done pulse", n_pulse - base, 1);

        // R8: entry 1 decays to exactly zero while entry 0 stays active
        do_reset();
        end_interval(4'b0011);
        check("R2 two active", int'(count_o), 8192);
        end_interval(4'b0001);
        check("R3 one decay step", int'(count_o), 7936);
        for (int k = 0; k < 300; k++) end_interval(4'b0001);
        check("R8 flushed to zero", int'(count_o), 4096);

        report();
    end
endmodule